// File: doc/BRIEF.md
# PCI configuration address/data port

This block is the host-side window through which software reaches the configuration space of devices behind a PCI host bridge. Software first writes a target address into a word-wide address register. It then reads or writes a data window. Each data-window access becomes one configuration request on a downstream request/response interface. The request carries the stored address with its two low bits replaced by the byte offset of the access, plus the access width of 1, 2 or 4 bytes. Configuration space is little-endian, so data for 2-byte and 4-byte accesses is byte-swapped to and from host order on the way through.

Reads of the data window are allowed only while the top bit of the address register is set. With that bit clear, a read never reaches the bus and returns all-ones at the requested width. Writes always go out. The block also holds a small combinational router. It folds the interrupt pins of each device slot onto a single board line and drives the matching interrupt-controller input.

The CPU side is a valid/ready request channel. `cpu_ready` drops while a gated-on read waits for the bus, and that is the only back-pressure. Read results come back as a one-cycle `cpu_rvalid` pulse with no ready. The requester must take the result in that cycle. Writes produce no response. Downstream requests are one-cycle pulses. The bus side answers a read with a one-cycle `cfg_rvalid` pulse and applies no back-pressure.

Top module: `pci_cfg_port`

## Requirements
- R1: After reset the address register reads 0, `cpu_ready` is 1, and `cfg_valid` and `cpu_rvalid` are 0.
- R2: A write at offset 0 (`cpu_addr[2]`=0) stores `cpu_wdata` with bits [1:0] forced to 0. A read at offset 0 returns the stored value on `cpu_rvalid` in the cycle after acceptance.
- R3: A data-window read (`cpu_addr[2]`=1) with address bit 31 set issues one request with `cfg_write`=0, `cfg_addr` = stored address OR `cpu_addr[1:0]`, and `cfg_size` = `cpu_size`. The result appears on `cpu_rvalid` in the cycle after `cfg_rvalid`.
- R4: A data-window read with address bit 31 clear issues no request. It answers in the next cycle with 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 0, 1 and 2, zero-extended.
- R5: A data-window write issues one request whatever the state of bit 31, in the cycle after acceptance. It carries `cfg_write`=1 and the address formed as in R3, and it produces no `cpu_rvalid`.
- R6: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Write data is converted as follows. For size 0 the bus data is `{24'b0, d[7:0]}`. For size 1 it is `{16'b0, d[7:0], d[15:8]}`. For size 2 the four bytes are reversed.
- R7: Read data from `cfg_rdata` is converted with the same mapping as R6 before it reaches `cpu_rdata`. Bits above the access width are dropped.
- R8: `cpu_ready` is 0 from the cycle after a gated-on read is accepted until its result is returned.
- R9: Pins `dev_intx[4*(s-1) +: 4]` of slot s (s = 1..4) are ORed onto board line s+1, which drives `ctrl_irq[29-s]` (lines 2..5 onto inputs 28..25). Every other `ctrl_irq` bit is 0.
- R10: A read request holds `cfg_valid` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Block can accept a CPU request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Bit 2 selects data window; bits [1:0] byte offset |
| cpu_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | Write data, host order, low-aligned |
| cpu_rvalid | output | 1 | Read result pulse |
| cpu_rdata | output | 32 | Read result, host order |
| cfg_valid | output | 1 | Configuration request pulse |
| cfg_write | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration address |
| cfg_size | output | 2 | Request width code |
| cfg_wdata | output | 32 | Write data, little-endian order |
| cfg_rvalid | input | 1 | Read data pulse from bus |
| cfg_rdata | input | 32 | Read data, little-endian order |
| dev_intx | input | 16 | Device interrupt pins, four per slot |
| ctrl_irq | output | 32 | Interrupt-controller inputs |

## Verification
The bench builds the block with its defaults: 32-bit data and address, four slots of four pins, first slot 1 and sink top 30. With these values the routed inputs are 28 down to 25, so a single pin in each slot and mixed pin patterns can be checked bit by bit. The 32-bit word makes the full four-byte reversal visible against the halfword and byte mappings. The bus model answers two cycles late and returns data wider than requested. This exposes the `cpu_ready` stall and the dropping of the upper bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } port_state_e;

endpackage

// File: rtl/cfgp_lane_swap.sv
module cfgp_lane_swap
  import cfgp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] rev;

  // full-width reversal of byte lanes
  for (genvar i = 0; i < NB; i++) begin : g_rev
    assign rev[8*i +: 8] = din[8*(NB-1-i) +: 8];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: dout = {{(DATA_W-8){1'b0}}, din[7:0]};
      SZ_HALF: dout = {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]};
      default: dout = rev;
    endcase
  end

endmodule

// File: rtl/cfgp_irq_route.sv
module cfgp_irq_route #(
  parameter int NUM_SLOTS     = 4,
  parameter int PINS_PER_SLOT = 4,
  parameter int FIRST_SLOT    = 1,
  parameter int IRQ_W         = 32,
  parameter int SINK_TOP      = 30
) (
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_intx,
  output logic [IRQ_W-1:0]                   ctrl_irq
);
  // board line = slot + 1, sink = SINK_TOP - line
  localparam int SINK_HI = SINK_TOP - FIRST_SLOT - 1;

  logic [NUM_SLOTS-1:0] slot_any;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_any[s] = |dev_intx[s*PINS_PER_SLOT +: PINS_PER_SLOT];
  end

  always_comb begin
    ctrl_irq = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      ctrl_irq[SINK_HI - s] = slot_any[s];
    end
  end

endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import cfgp_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 32,
  parameter int NUM_SLOTS     = 4,
  parameter int PINS_PER_SLOT = 4,
  parameter int FIRST_SLOT    = 1,
  parameter int IRQ_W         = 32,
  parameter int SINK_TOP      = 30
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cpu_valid,
  output logic                               cpu_ready,
  input  logic                               cpu_write,
  input  logic [2:0]                         cpu_addr,
  input  logic [1:0]                         cpu_size,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  output logic                               cpu_rvalid,
  output logic [DATA_W-1:0]                  cpu_rdata,
  output logic                               cfg_valid,
  output logic                               cfg_write,
  output logic [ADDR_W-1:0]                  cfg_addr,
  output logic [1:0]                         cfg_size,
  output logic [DATA_W-1:0]                  cfg_wdata,
  input  logic                               cfg_rvalid,
  input  logic [DATA_W-1:0]                  cfg_rdata,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_intx,
  output logic [IRQ_W-1:0]                   ctrl_irq
);
  localparam int EN_BIT = ADDR_W - 1;

  port_state_e       st;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              accept;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] wr_bus;
  logic [DATA_W-1:0] rd_host;
  logic [DATA_W-1:0] gated_val;

  assign cpu_ready = (st == ST_IDLE);
  assign accept    = cpu_valid && cpu_ready;
  assign req_addr  = addr_q | {{(ADDR_W-2){1'b0}}, cpu_addr[1:0]};

  always_comb begin
    unique case (cpu_size)
      SZ_BYTE: gated_val = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_HALF: gated_val = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: gated_val = '1;
    endcase
  end

  cfgp_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .size (cpu_size),
    .din  (cpu_wdata),
    .dout (wr_bus)
  );

  cfgp_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .size (size_q),
    .din  (cfg_rdata),
    .dout (rd_host)
  );

  cfgp_irq_route #(
    .NUM_SLOTS     (NUM_SLOTS),
    .PINS_PER_SLOT (PINS_PER_SLOT),
    .FIRST_SLOT    (FIRST_SLOT),
    .IRQ_W         (IRQ_W),
    .SINK_TOP      (SINK_TOP)
  ) u_route (
    .dev_intx (dev_intx),
    .ctrl_irq (ctrl_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      size_q     <= '0;
      cfg_valid  <= 1'b0;
      cfg_write  <= 1'b0;
      cfg_addr   <= '0;
      cfg_size   <= '0;
      cfg_wdata  <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cfg_valid  <= 1'b0;
      cpu_rvalid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!cpu_addr[2]) begin
              if (cpu_write) begin
                addr_q <= {cpu_wdata[ADDR_W-1:2], 2'b00};
              end else begin
                cpu_rvalid <= 1'b1;
                cpu_rdata  <= DATA_W'(addr_q);
              end
            end else if (cpu_write) begin
              cfg_valid <= 1'b1;
              cfg_write <= 1'b1;
              cfg_addr  <= req_addr;
              cfg_size  <= cpu_size;
              cfg_wdata <= wr_bus;
            end else if (addr_q[EN_BIT]) begin
              cfg_valid <= 1'b1;
              cfg_write <= 1'b0;
              cfg_addr  <= req_addr;
              cfg_size  <= cpu_size;
              cfg_wdata <= '0;
              size_q    <= cpu_size;
              st        <= ST_WAIT;
            end else begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= gated_val;
            end
          end
        end
        default: begin
          if (cfg_rvalid) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= rd_host;
            st         <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // a read request on the bus only ever happens with the enable bit set
  assert_read_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_write) |-> cfg_addr[EN_BIT]);

  // read requests are single-cycle pulses
  assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_write) |=> !cfg_valid);

  // CPU channel is stalled while a read is outstanding on the bus
  assert_stall_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_write) |-> !cpu_ready);

  // a read result follows either a bus response or a locally answered read
  assert_rsp_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> ($past(cfg_rvalid) || $past(cpu_valid && !cpu_write)));

  // address-register reads never show the two low bits
  assert_addr_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(cpu_valid && cpu_ready && !cpu_write && !cpu_addr[2]))
      |-> (cpu_rdata[1:0] == 2'b00));

endmodule

// File: tb/sim_pci_cfg_port.sv
module sim_pci_cfg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_write = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        cfg_valid;
  logic        cfg_write;
  logic [31:0] cfg_addr;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic        cfg_rvalid = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [15:0] dev_intx = '0;
  logic [31:0] ctrl_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  pci_cfg_port u0 (
    .clk, .rst_n, .cpu_valid, .cpu_ready, .cpu_write, .cpu_addr, .cpu_size,
    .cpu_wdata, .cpu_rvalid, .cpu_rdata, .cfg_valid, .cfg_write, .cfg_addr,
    .cfg_size, .cfg_wdata, .cfg_rvalid, .cfg_rdata, .dev_intx, .ctrl_irq
  );

  // scoreboards
  logic [66:0] exp_req[$];
  string       exp_req_tag[$];
  logic [31:0] exp_rd[$];
  string       exp_rd_tag[$];

  logic [31:0] addr_model = '0;

  function automatic logic [31:0] swap_ref(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {24'b0, d[7:0]};
      2'd1:    return {16'b0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [31:0] ones_ref(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0] ^ 8'h5C, a[7:0] ^ 8'hA3, a[15:8] ^ 8'h19, a[7:0] + 8'h07};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cpu_op(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic wr_addr(input logic [31:0] v);
    addr_model = {v[31:2], 2'b00};
    cpu_op(1'b1, 3'd0, 2'd2, v);
  endtask

  task automatic rd_addr(input string tag);
    exp_rd.push_back(addr_model); exp_rd_tag.push_back(tag);
    cpu_op(1'b0, 3'd0, 2'd2, 32'h0);
  endtask

  task automatic wr_data(input logic [1:0] off, input logic [1:0] sz,
                         input logic [31:0] v, input string tag);
    exp_req.push_back({1'b1, sz, addr_model | {30'b0, off}, swap_ref(sz, v)});
    exp_req_tag.push_back(tag);
    cpu_op(1'b1, {1'b1, off}, sz, v);
  endtask

  task automatic rd_data(input logic [1:0] off, input logic [1:0] sz, input string tag);
    logic [31:0] ra;
    ra = addr_model | {30'b0, off};
    if (addr_model[31]) begin
      exp_req.push_back({1'b0, sz, ra, 32'h0}); exp_req_tag.push_back(tag);
      exp_rd.push_back(swap_ref(sz, pat(ra)));  exp_rd_tag.push_back(tag);
      cpu_op(1'b0, {1'b1, off}, sz, 32'h0);
      check("R8 ready low while read outstanding", {31'b0, cpu_ready}, 32'h0);
    end else begin
      exp_rd.push_back(ones_ref(sz)); exp_rd_tag.push_back(tag);
      cpu_op(1'b0, {1'b1, off}, sz, 32'h0);
    end
  endtask

  // bus target and monitor
  int          resp_cnt = 0;
  logic [31:0] resp_data = '0;

  always @(negedge clk) begin
    cfg_rvalid = 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        cfg_rvalid = 1'b1;
        cfg_rdata  = resp_data;
      end
    end
    if (rst_n && cfg_valid) begin
      n_checks++;
      if (exp_req.size() == 0) begin
        n_fail++;
        $display("FAIL R4/R10 unexpected request got %h expected none", cfg_addr);
      end else begin
        logic [66:0] e;
        string t;
        e = exp_req.pop_front(); t = exp_req_tag.pop_front();
        if ({cfg_write, cfg_size, cfg_addr, cfg_write ? cfg_wdata : 32'h0} !== e) begin
          n_fail++;
          $display("FAIL %s request got %h expected %h", t,
                   {cfg_write, cfg_size, cfg_addr, cfg_write ? cfg_wdata : 32'h0}, e);
        end
      end
      if (!cfg_write) begin
        resp_cnt  = 2;
        resp_data = pat(cfg_addr);
      end
    end
    if (rst_n && cpu_rvalid) begin
      if (exp_rd.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R5 unexpected read result got %h expected none", cpu_rdata);
      end else begin
        string t;
        t = exp_rd_tag.pop_front();
        check(t, cpu_rdata, exp_rd.pop_front());
      end
    end
  end

  task automatic irq_case(input logic [15:0] pins);
    logic [31:0] e;
    e = '0;
    for (int s = 0; s < 4; s++) e[28 - s] = |pins[4*s +: 4];
    dev_intx = pins;
    #1;
    check("R9 interrupt routing", ctrl_irq, e);
  endtask

  task automatic drain;
    int n;
    n = 0;
    while ((exp_req.size() != 0 || exp_rd.size() != 0) && n < 200) begin
      @(negedge clk); n++;
    end
    n_checks++;
    if (exp_req.size() != 0 || exp_rd.size() != 0) begin
      n_fail++;
      $display("FAIL R3 outstanding items got %0d expected 0", exp_req.size() + exp_rd.size());
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, cpu_ready}, 32'h1);
    check("R1 no request after reset", {31'b0, cfg_valid}, 32'h0);
    check("R1 no result after reset", {31'b0, cpu_rvalid}, 32'h0);
    rd_addr("R1 address register reset value");

    wr_addr(32'h8000_1237);
    rd_addr("R2 address low bits cleared");

    rd_data(2'd0, 2'd2, "R3 R7 word read");
    rd_data(2'd2, 2'd1, "R3 R7 halfword read");
    rd_data(2'd3, 2'd0, "R3 R7 byte read");
    rd_data(2'd1, 2'd0, "R3 back-to-back read");

    wr_data(2'd0, 2'd2, 32'h1122_3344, "R6 word write swap");
    wr_data(2'd2, 2'd1, 32'h0000_ABCD, "R6 halfword write swap");
    wr_data(2'd1, 2'd0, 32'hFFFF_FF5A, "R6 byte write");

    wr_addr(32'h0000_0812);
    rd_addr("R2 disabled address readback");
    rd_data(2'd0, 2'd0, "R4 gated byte read");
    rd_data(2'd2, 2'd1, "R4 gated halfword read");
    rd_data(2'd0, 2'd2, "R4 gated word read");
    wr_data(2'd3, 2'd0, 32'h0000_00C3, "R5 write with enable clear");
    wr_data(2'd0, 2'd2, 32'hDEAD_BEEF, "R5 word write with enable clear");

    wr_addr(32'hC0FF_EE04);
    rd_data(2'd1, 2'd2, "R10 read at odd offset");
    drain();

    irq_case(16'h0000);
    irq_case(16'h0001);
    irq_case(16'h0020);
    irq_case(16'h0400);
    irq_case(16'h8000);
    irq_case(16'hFFFF);
    irq_case(16'h0F0A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule